// File: doc/BRIEF.md
# Smart Card Transmit-End Timing Generator

This block follows one character on a half-duplex smart card line and decides when the transmit-end flag rises. Time is counted in elementary time units (etu), where one etu is the length of one bit on the line. A programmable `etuClocks` input gives the number of system clocks in one etu. Internally the block counts in half-etu steps, so thresholds at a half-etu boundary fall on an exact clock edge.

Software writes new transmit data, which is signalled by `txLoad`. This clears the flag and arms the timer. The following `startBit` strobe marks the first clock of the start bit and starts the count. The flag then rises after 12.5 etu in normal mode, 11.5 etu in block-transfer mode, or 11.0 etu in GSM mode.

The block also drives the card clock output. In normal mode the card clock can only be stopped or running. In GSM mode it can also be parked high or low. A change of clock mode takes effect only at the end of a low half-period, so the output never shows a shortened pulse.

Top module: `scTxEndTimer`

## Requirements
- R1: After reset, `txEnd` is 1, `cardClk` is 0 and the clock mode applied is "stopped".
- R2: In normal mode (`gsmMode`=0, `blockMode`=0), `txEnd` rises on the clock edge that comes 25·(`etuClocks`/2) clocks after the edge that samples an accepted `startBit`. That is 12.5 etu.
- R3: `txLoad` clears `txEnd` on the next edge and arms the timer. A `startBit` is accepted only while the timer is armed. A `startBit` at any other time is ignored, including a second strobe during a running count. When `txLoad` falls in the same cycle as a `startBit` or as the expiry edge, `txLoad` wins: `txEnd` stays 0 and the timer stays armed.
- R4: Once set, `txEnd` stays 1 until the next `txLoad`.
- R5: In block-transfer mode (`gsmMode`=0, `blockMode`=1), the threshold is 23 half-etu, which is 11.5 etu.
- R6: In GSM mode (`gsmMode`=1), the threshold is 22 half-etu, which is 11.0 etu, whatever the value of `blockMode`.
- R7: `etuClocks`, `gsmMode` and `blockMode` are captured at the accepted start strobe. Changes to them during the count do not move the expiry.
- R8: `clkMode` is decoded as 00 stopped low, 01 running, 10 parked low and 11 parked high. In normal mode bit 1 is ignored, so 10 acts as stopped and 11 acts as running.
- R9: In GSM mode, code 10 holds `cardClk` at 0 and code 11 holds it at 1.
- R10: A new clock mode is applied only on the edge that ends a low half-period of the internal card-clock divider. Every level of `cardClk` therefore lasts at least `CK_HALF` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| etuClocks | input | ETU_W | System clocks per etu (even, at least 2) |
| txLoad | input | 1 | New transmit data written: clear flag, arm timer |
| startBit | input | 1 | Strobe on the first clock of the start bit |
| blockMode | input | 1 | Block-transfer timing select |
| gsmMode | input | 1 | GSM timing and extended clock control |
| clkMode | input | 2 | Requested card clock mode |
| txEnd | output | 1 | Transmit-end flag |
| cardClk | output | 1 | Card clock output |

## Verification
Two events can fall in the same cycle: the expiry of a count and a fresh `txLoad`, or an arming `txLoad` and a `startBit`. The bench raises `txLoad` exactly on the edge where the flag would otherwise rise, and separately pulses `txLoad` together with `startBit`. In both cases it expects `txEnd` to stay 0 and no later rise until a new start strobe is accepted. It then checks that the next accepted start strobe gives a correctly timed rise.

// File: rtl/scTxPkg.sv
package scTxPkg;

  localparam int HALF_W = 5;
  localparam logic [HALF_W-1:0] THR_NORMAL = 5'd25;
  localparam logic [HALF_W-1:0] THR_BLOCK  = 5'd23;
  localparam logic [HALF_W-1:0] THR_GSM    = 5'd22;

  typedef enum logic [1:0] {
    CK_STOP     = 2'b00,
    CK_RUN      = 2'b01,
    CK_PARK_LO  = 2'b10,
    CK_PARK_HI  = 2'b11
  } ckMode_e;

  typedef struct packed {
    logic clrEnd;
    logic setEnd;
    logic startCnt;
    logic countEn;
  } timerCtl_t;

  function automatic logic [HALF_W-1:0] thrHalves(input logic gsm, input logic blk);
    if (gsm)      return THR_GSM;
    else if (blk) return THR_BLOCK;
    else          return THR_NORMAL;
  endfunction

  function automatic logic ckLevel(input ckMode_e code, input logic phase);
    case (code)
      CK_RUN:     return phase;
      CK_PARK_HI: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/scTxCtrl.sv
module scTxCtrl
  import scTxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txLoad,
  input  logic      startBit,
  input  logic      hit,
  output timerCtl_t ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_TIMING} st_e;
  st_e state, stateNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    if (txLoad) begin
      ctl.clrEnd = 1'b1;
      stateNxt   = ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: if (startBit) begin
          ctl.startCnt = 1'b1;
          stateNxt     = ST_TIMING;
        end
        ST_TIMING: begin
          ctl.countEn = 1'b1;
          if (hit) begin
            ctl.setEnd = 1'b1;
            stateNxt   = ST_IDLE;
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/scTxDatapath.sv
module scTxDatapath
  import scTxPkg::*;
#(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ETU_W-1:0] etuClocks,
  input  logic             gsmMode,
  input  logic             blockMode,
  input  timerCtl_t        ctl,
  output logic             hit,
  output logic             txEnd
);

  localparam int SUB_W = ETU_W - 1;

  logic [SUB_W-1:0]  halfLen, subCnt;
  logic [HALF_W-1:0] thrQ, halfCnt;
  logic              subWrap;

  assign subWrap = (subCnt == halfLen - SUB_W'(1));
  assign hit     = subWrap && (halfCnt == thrQ - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfLen <= SUB_W'(1);
      thrQ    <= THR_NORMAL;
      subCnt  <= '0;
      halfCnt <= '0;
    end else if (ctl.startCnt) begin
      halfLen <= etuClocks[ETU_W-1:1];
      thrQ    <= thrHalves(gsmMode, blockMode);
      subCnt  <= '0;
      halfCnt <= '0;
    end else if (ctl.countEn) begin
      if (subWrap) begin
        subCnt  <= '0;
        halfCnt <= halfCnt + HALF_W'(1);
      end else begin
        subCnt  <= subCnt + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           txEnd <= 1'b1;
    else if (ctl.clrEnd) txEnd <= 1'b0;
    else if (ctl.setEnd) txEnd <= 1'b1;
  end

endmodule

// File: rtl/scCardClk.sv
module scCardClk
  import scTxPkg::*;
#(
  parameter int CK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gsmMode,
  input  logic [1:0] clkMode,
  output logic       cardClk
);

  localparam int DIV_W = (CK_HALF > 1) ? $clog2(CK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CK_HALF - 1);

  logic [DIV_W-1:0] divCnt;
  logic             ckPhase, phaseNxt, divWrap, applyNow;
  ckMode_e          appliedCode, reqCode;

  assign reqCode  = gsmMode ? ckMode_e'(clkMode) : ckMode_e'({1'b0, clkMode[0]});
  assign divWrap  = (divCnt == DIV_LAST);
  assign phaseNxt = divWrap ? ~ckPhase : ckPhase;
  assign applyNow = divWrap && !ckPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt      <= '0;
      ckPhase     <= 1'b0;
      appliedCode <= CK_STOP;
      cardClk     <= 1'b0;
    end else begin
      divCnt  <= divWrap ? '0 : divCnt + DIV_W'(1);
      ckPhase <= phaseNxt;
      if (applyNow) begin
        appliedCode <= reqCode;
        cardClk     <= ckLevel(reqCode, phaseNxt);
      end else begin
        cardClk     <= ckLevel(appliedCode, phaseNxt);
      end
    end
  end

endmodule

// File: rtl/scTxEndTimer.sv
module scTxEndTimer
  import scTxPkg::*;
#(
  parameter int ETU_W   = 12,
  parameter int CK_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ETU_W-1:0] etuClocks,
  input  logic             txLoad,
  input  logic             startBit,
  input  logic             blockMode,
  input  logic             gsmMode,
  input  logic [1:0]       clkMode,
  output logic             txEnd,
  output logic             cardClk
);

  timerCtl_t ctl;
  logic      hit;

  scTxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .txLoad(txLoad), .startBit(startBit),
    .hit(hit), .ctl(ctl)
  );

  scTxDatapath #(.ETU_W(ETU_W)) u_dp (
    .clk(clk), .rstN(rstN), .etuClocks(etuClocks), .gsmMode(gsmMode),
    .blockMode(blockMode), .ctl(ctl), .hit(hit), .txEnd(txEnd)
  );

  scCardClk #(.CK_HALF(CK_HALF)) u_ck (
    .clk(clk), .rstN(rstN), .gsmMode(gsmMode), .clkMode(clkMode),
    .cardClk(cardClk)
  );

endmodule

// File: rtl/scTxEndTimer_chk.sv
module scTxEndTimer_chk (
  input logic clk,
  input logic rstN,
  input logic txLoad,
  input logic startBit,
  input logic txEnd,
  input logic cardClk
);

  logic [15:0] sinceLoad;

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceLoad <= '0;
    else if (txLoad)            sinceLoad <= '0;
    else if (sinceLoad != '1)   sinceLoad <= sinceLoad + 16'd1;
  end

  AST_LOAD_CLEARS_END: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txEnd); // R3

  AST_END_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txEnd && !txLoad) |=> txEnd); // R4

  AST_END_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> (sinceLoad >= 16'd22 && !startBit)); // R2

  AST_CLK_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    (cardClk != $past(cardClk)) |=> $stable(cardClk)); // R10

endmodule

bind scTxEndTimer scTxEndTimer_chk u_chk (
  .clk(clk), .rstN(rstN), .txLoad(txLoad), .startBit(startBit),
  .txEnd(txEnd), .cardClk(cardClk)
);

// File: tb/tb_scTxEndTimer.sv
module tb_scTxEndTimer;

  localparam int ETU_W   = 12;
  localparam int CK_HALF = 2;

  logic             clk = 1'b0;
  logic             rstN;
  logic [ETU_W-1:0] etuClocks;
  logic             txLoad, startBit, blockMode, gsmMode;
  logic [1:0]       clkMode;
  logic             txEnd, cardClk;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  scTxEndTimer #(.ETU_W(ETU_W), .CK_HALF(CK_HALF)) dut (
    .clk(clk), .rstN(rstN), .etuClocks(etuClocks), .txLoad(txLoad),
    .startBit(startBit), .blockMode(blockMode), .gsmMode(gsmMode),
    .clkMode(clkMode), .txEnd(txEnd), .cardClk(cardClk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int expCycles(input int e, input bit g, input bit b);
    int halves;
    halves = g ? 22 : (b ? 23 : 25);
    return halves * (e / 2);
  endfunction

  function automatic string modeReq(input bit g, input bit b);
    return g ? "R6" : (b ? "R5" : "R2");
  endfunction

  // runt monitor for R10
  int  runLen = 0;
  int  runtCnt = 0;
  bit  seenChange = 0;
  logic prevClk = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (cardClk == prevClk) runLen++;
      else begin
        if (seenChange && runLen < CK_HALF) runtCnt++;
        seenChange = 1;
        runLen = 1;
      end
      prevClk = cardClk;
    end
  end

  // accepted start strobe followed by exact timing check
  task automatic startAndCheck(input int e, input bit g, input bit b,
                               input bit disturb, input bit loadAtEnd);
    int n;
    string rq;
    n  = expCycles(e, g, b);
    rq = disturb ? "R7" : modeReq(g, b);
    @(negedge clk);
    etuClocks = ETU_W'(e); gsmMode = g; blockMode = b; startBit = 1'b1;
    @(negedge clk);
    startBit = 1'b0;
    if (disturb) begin
      gsmMode = ~g; blockMode = ~b; etuClocks = ETU_W'(e + 2);
    end
    for (int j = 1; j < n; j++) begin
      @(negedge clk);
      if (disturb && j == 2) startBit = 1'b1;
      if (disturb && j == 3) startBit = 1'b0;
    end
    chk(txEnd == 1'b0, rq, txEnd, 0);
    if (loadAtEnd) begin
      txLoad = 1'b1;
      @(negedge clk);
      txLoad = 1'b0;
      chk(txEnd == 1'b0, "R3", txEnd, 0);
      repeat (40) @(negedge clk);
      chk(txEnd == 1'b0, "R3", txEnd, 0);
    end else begin
      @(negedge clk);
      chk(txEnd == 1'b1, rq, txEnd, 1);
      repeat (5) @(negedge clk);
      chk(txEnd == 1'b1, "R4", txEnd, 1);
    end
  endtask

  task automatic loadData();
    @(negedge clk);
    txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
    chk(txEnd == 1'b0, "R3", txEnd, 0);
  endtask

  task automatic doChar(input int e, input bit g, input bit b, input bit disturb);
    loadData();
    startAndCheck(e, g, b, disturb, 1'b0);
  endtask

  // expKind: 0 always low, 1 toggling, 2 always high
  task automatic clkCase(input bit g, input logic [1:0] code, input int expKind, input string rq);
    int highs;
    @(negedge clk);
    gsmMode = g; clkMode = code;
    repeat (4 * CK_HALF + 2) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 8 * CK_HALF; k++) begin
      @(negedge clk);
      if (cardClk) highs++;
    end
    if (expKind == 0)      chk(highs == 0, rq, highs, 0);
    else if (expKind == 2) chk(highs == 8 * CK_HALF, rq, highs, 8 * CK_HALF);
    else                   chk(highs == 4 * CK_HALF, rq, highs, 4 * CK_HALF);
  endtask

  initial begin
    int unsigned seed;
    rstN = 1'b0; etuClocks = ETU_W'(4); txLoad = 1'b0; startBit = 1'b0;
    blockMode = 1'b0; gsmMode = 1'b0; clkMode = 2'b00;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(txEnd == 1'b1, "R1", txEnd, 1);
    chk(cardClk == 1'b0, "R1", cardClk, 0);
    rstN = 1'b1;
    @(negedge clk);

    // start without arming is ignored
    startBit = 1'b1; @(negedge clk); startBit = 1'b0;
    repeat (30) @(negedge clk);
    chk(txEnd == 1'b1, "R3", txEnd, 1);

    // armed but no start: no rise
    loadData();
    repeat (60) @(negedge clk);
    chk(txEnd == 1'b0, "R3", txEnd, 0);
    startAndCheck(2, 1'b0, 1'b0, 1'b0, 1'b0);

    // directed modes
    doChar(2, 1'b0, 1'b0, 1'b0);
    doChar(2, 1'b0, 1'b1, 1'b0);
    doChar(2, 1'b1, 1'b0, 1'b0);
    doChar(2, 1'b1, 1'b1, 1'b0);
    doChar(8, 1'b0, 1'b0, 1'b0);
    doChar(6, 1'b0, 1'b1, 1'b0);
    doChar(4, 1'b0, 1'b0, 1'b1);
    doChar(10, 1'b1, 1'b0, 1'b1);

    // txLoad on the expiry edge wins
    loadData();
    startAndCheck(4, 1'b0, 1'b0, 1'b0, 1'b1);
    startAndCheck(4, 1'b0, 1'b1, 1'b0, 1'b0);

    // txLoad together with start: start ignored, stays armed
    loadData();
    @(negedge clk);
    txLoad = 1'b1; startBit = 1'b1;
    @(negedge clk);
    txLoad = 1'b0; startBit = 1'b0;
    repeat (60) @(negedge clk);
    chk(txEnd == 1'b0, "R3", txEnd, 0);
    startAndCheck(2, 1'b1, 1'b0, 1'b0, 1'b0);

    // random characters
    for (int i = 0; i < 16; i++) begin
      int e;
      bit g, b, d;
      e = 2 * (1 + int'($urandom % 8));
      g = 1'($urandom); b = 1'($urandom); d = 1'($urandom);
      doChar(e, g, b, d);
    end

    // clock output modes
    clkCase(1'b0, 2'b00, 0, "R8");
    clkCase(1'b0, 2'b01, 1, "R8");
    clkCase(1'b0, 2'b10, 0, "R8");
    clkCase(1'b0, 2'b11, 1, "R8");
    clkCase(1'b1, 2'b01, 1, "R9");
    clkCase(1'b1, 2'b10, 0, "R9");
    clkCase(1'b1, 2'b11, 2, "R9");
    clkCase(1'b1, 2'b00, 0, "R9");

    // random mode changes at random times, then runt check
    for (int i = 0; i < 60; i++) begin
      repeat (1 + ($urandom % 7)) @(negedge clk);
      gsmMode = 1'($urandom);
      clkMode = 2'($urandom);
    end
    repeat (10) @(negedge clk);
    chk(runtCnt == 0, "R10", runtCnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule